// File: doc/BRIEF.md
# Output-Stage Power-Up Sequencer

This block decides when a stereo (or wider) PWM output stage may drive audio. It holds the differential PWM pairs in a forced hard-mute pattern until the power-down pin and the PLL lock are both good and an initialization interval has elapsed. It then raises the per-channel valid flags and lets the modulator's P and M outputs through. A pulse marks the end of initialization for the logic that follows.

The length of the initialization interval depends on the order in which the two low-active controls were released. If power-down was still asserted after the block's reset was removed, and is released later, the long interval applies. If power-down was already released before reset was removed, or the block is re-arming after a lock loss or a serial mode change, the short interval applies. Both lengths are master-clock counts set by parameters. While operating, a low mute input asks the downstream logic for a soft mute and leaves the valid flags high. Power-down, lock loss or a mode change drops straight back to hard mute.

Top module: `outstage_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, valid_o is all zero, hard_mute_o is 1, soft_mute_o is 0 and init_done_o is 0.
- R2: Whenever hard_mute_o is 1, every pwm_p_o bit is 0 and every pwm_m_o bit is 1. When hard_mute_o is 0, pwm_p_o equals mod_p_i and pwm_m_o equals mod_m_i.
- R3: If pdn_ni is low after reset and is released later, with lock_i high, valid_o rises exactly LONG_CYC+1 clock edges after the first edge that samples pdn_ni high.
- R4: If pdn_ni and lock_i are already high when rst_ni rises, valid_o rises exactly SHORT_CYC+1 clock edges after rst_ni rises.
- R5: init_done_o is a single-cycle pulse that is high in the first cycle that valid_o is high.
- R6: If lock_i is sampled low, valid_o is all zero and hard_mute_o is 1 from the next cycle on. The block stays there while lock_i is low. Once lock_i is sampled high again it re-initializes with the short interval.
- R7: A change of the 3-bit mode_i value returns the block to hard mute on the next edge. It re-initializes with the short interval, so valid_o rises SHORT_CYC+2 edges after the change.
- R8: soft_mute_o is 1 only while operating (valid_o high) with mute_ni low. Mute never lowers valid_o and never forces the PWM pairs.
- R9: pdn_ni sampled low during operation gives hard mute with valid_o zero on the next edge. The following power-down release uses the long interval.
- R10: All bits of valid_o always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| pdn_ni | input | 1 | power-down, active low |
| mute_ni | input | 1 | mute, active low (0 = muted) |
| lock_i | input | 1 | PLL lock indication |
| mode_i | input | MODE_W | serial format selection, watched for changes |
| mod_p_i | input | N_CH | modulator positive outputs |
| mod_m_i | input | N_CH | modulator negative outputs |
| pwm_p_o | output | N_CH | gated positive PWM outputs |
| pwm_m_o | output | N_CH | gated negative PWM outputs |
| valid_o | output | N_CH | per-channel output valid |
| hard_mute_o | output | 1 | hard-mute state indication |
| soft_mute_o | output | 1 | soft-mute request |
| init_done_o | output | 1 | initialization finished pulse |

## Verification
The bench measures the exact number of edges to valid for both release orders. A design that chose the interval from the wrong release order, or that was off by one in its counter, would raise valid too early or too late by a measurable count. It also re-arms the block after a lock loss, a mode change and a power-down in operation. A sequencer that kept the long-interval flag set, or ignored a mode change, would show the wrong timing or would keep valid high. Mute vectors applied in operation and in hard mute catch a soft mute that leaks outside operation or that disturbs the PWM pass-through.

// File: rtl/outstage_pkg.sv
package outstage_pkg;
  typedef enum logic [1:0] {
    ST_HMUTE = 2'd0,
    ST_INIT  = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mode_watch.sv
module mode_watch #(
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  output logic              chg_o
);
  logic [MODE_W-1:0] mode_q;
  logic              primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      mode_q   <= mode_i;
      primed_q <= 1'b1;
    end
  end

  // first sample after reset only primes the reference
  assign chg_o = primed_q && (mode_i != mode_q);
endmodule

// File: rtl/init_timer.sv
module init_timer #(
  parameter int unsigned SHORT_CYC = 61440,
  parameter int unsigned LONG_CYC  = 1228800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic long_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = long_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
  assign done_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mute_gate.sv
module mute_gate #(
  parameter int unsigned N_CH = 2
) (
  input  logic            hard_i,
  input  logic [N_CH-1:0] p_i,
  input  logic [N_CH-1:0] m_i,
  output logic [N_CH-1:0] p_o,
  output logic [N_CH-1:0] m_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign p_o[g] = hard_i ? 1'b0 : p_i[g];
    assign m_o[g] = hard_i ? 1'b1 : m_i[g];
  end
endmodule

// File: rtl/outstage_seq.sv
module outstage_seq
  import outstage_pkg::*;
#(
  parameter int unsigned N_CH      = 2,
  parameter int unsigned MODE_W    = 3,
  parameter int unsigned SHORT_CYC = 61440,
  parameter int unsigned LONG_CYC  = 1228800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdn_ni,
  input  logic              mute_ni,
  input  logic              lock_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [N_CH-1:0]   mod_p_i,
  input  logic [N_CH-1:0]   mod_m_i,
  output logic [N_CH-1:0]   pwm_p_o,
  output logic [N_CH-1:0]   pwm_m_o,
  output logic [N_CH-1:0]   valid_o,
  output logic              hard_mute_o,
  output logic              soft_mute_o,
  output logic              init_done_o
);
  seq_state_e state_q, state_d;
  logic       long_q;
  logic       done_q;
  logic       chg;
  logic       tmr_done;
  logic       abort;

  mode_watch #(.MODE_W(MODE_W)) u_watch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .chg_o (chg)
  );

  init_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_INIT),
    .long_i(long_q),
    .done_o(tmr_done)
  );

  assign abort = !pdn_ni || !lock_i || chg;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HMUTE: if (!abort) state_d = ST_INIT;
      ST_INIT: begin
        if (abort)         state_d = ST_HMUTE;
        else if (tmr_done) state_d = ST_RUN;
      end
      ST_RUN:   if (abort) state_d = ST_HMUTE;
      default:  state_d = ST_HMUTE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HMUTE;
      long_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_INIT) && (state_d == ST_RUN);
      // remembers a power-down seen since the last completed init
      if (!pdn_ni)                                    long_q <= 1'b1;
      else if ((state_q == ST_INIT) && (state_d == ST_RUN)) long_q <= 1'b0;
    end
  end

  assign hard_mute_o = (state_q != ST_RUN);
  assign valid_o     = {N_CH{state_q == ST_RUN}};
  assign soft_mute_o = (state_q == ST_RUN) && !mute_ni;
  assign init_done_o = done_q;

  mute_gate #(.N_CH(N_CH)) u_gate (
    .hard_i(hard_mute_o),
    .p_i   (mod_p_i),
    .m_i   (mod_m_i),
    .p_o   (pwm_p_o),
    .m_o   (pwm_m_o)
  );
endmodule

// File: rtl/outstage_seq_chk.sv
module outstage_seq_chk #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned MODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pdn_ni,
  input logic              mute_ni,
  input logic              lock_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [N_CH-1:0]   pwm_p_o,
  input logic [N_CH-1:0]   pwm_m_o,
  input logic [N_CH-1:0]   valid_o,
  input logic              hard_mute_o,
  input logic              soft_mute_o,
  input logic              init_done_o
);
  a_r2_force_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_mute_o |-> (pwm_p_o == '0) && (pwm_m_o == '1));

  a_r10_valid_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o == '0) || (valid_o == '1));

  a_r6_lock_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> (valid_o == '0) && hard_mute_o);

  a_r9_power_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |=> (valid_o == '0) && hard_mute_o);

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> !init_done_o);

  a_r5_pulse_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o[0]) |-> init_done_o);

  a_r8_soft_scope: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_mute_o |-> valid_o[0] && !mute_ni && !hard_mute_o);
endmodule

bind outstage_seq outstage_seq_chk #(.N_CH(N_CH), .MODE_W(MODE_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pdn_ni     (pdn_ni),
  .mute_ni    (mute_ni),
  .lock_i     (lock_i),
  .mode_i     (mode_i),
  .pwm_p_o    (pwm_p_o),
  .pwm_m_o    (pwm_m_o),
  .valid_o    (valid_o),
  .hard_mute_o(hard_mute_o),
  .soft_mute_o(soft_mute_o),
  .init_done_o(init_done_o)
);

// File: tb/outstage_seq_tb.sv
`timescale 1ns/1ps
module outstage_seq_tb_top;
  localparam int unsigned N_CH   = 2;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned SHORT  = 20;
  localparam int unsigned LONG   = 60;

  // {mute_ni, mod_p, mod_m, exp_p, exp_m, exp_soft}
  localparam int NV = 6;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 2'b01, 2'b10, 2'b01, 2'b10, 1'b0},
    {1'b1, 2'b11, 2'b00, 2'b11, 2'b00, 1'b0},
    {1'b0, 2'b10, 2'b01, 2'b10, 2'b01, 1'b1},
    {1'b0, 2'b00, 2'b11, 2'b00, 2'b11, 1'b1},
    {1'b1, 2'b10, 2'b10, 2'b10, 2'b10, 1'b0},
    {1'b0, 2'b01, 2'b01, 2'b01, 2'b01, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pdn_ni = 1'b0;
  logic mute_ni = 1'b1;
  logic lock_i = 1'b0;
  logic [MODE_W-1:0] mode_i = 3'd2;
  logic [N_CH-1:0] mod_p_i = '0;
  logic [N_CH-1:0] mod_m_i = '0;
  logic [N_CH-1:0] pwm_p_o, pwm_m_o, valid_o;
  logic hard_mute_o, soft_mute_o, init_done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  outstage_seq #(.N_CH(N_CH), .MODE_W(MODE_W), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pdn_ni(pdn_ni), .mute_ni(mute_ni), .lock_i(lock_i),
    .mode_i(mode_i), .mod_p_i(mod_p_i), .mod_m_i(mod_m_i), .pwm_p_o(pwm_p_o),
    .pwm_m_o(pwm_m_o), .valid_o(valid_o), .hard_mute_o(hard_mute_o),
    .soft_mute_o(soft_mute_o), .init_done_o(init_done_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // steps until valid rises; also checks the done pulse in that cycle
  task automatic edges_to_valid(input string req, input int expect_n);
    int n = 0;
    bit pulse = 0;
    while (valid_o !== '1 && n < 4 * LONG) begin
      step();
      n++;
    end
    pulse = init_done_o;
    chk(req, n, expect_n);
    chk("R5 pulse", pulse, 1);
    step();
    chk("R5 single", init_done_o, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    // R1 reset state
    #12;
    chk("R1 valid", valid_o, 0);
    chk("R1 hard", hard_mute_o, 1);
    chk("R1 soft", soft_mute_o, 0);
    chk("R1 done", init_done_o, 0);
    chk("R2 p in reset", pwm_p_o, 0);
    chk("R2 m in reset", pwm_m_o, 2'b11);

    // R4: pdn and lock already high at reset release
    pdn_ni = 1; lock_i = 1;
    step();
    rst_ni = 1;
    chk("R1 after release", hard_mute_o, 1);
    edges_to_valid("R4 short after reset", SHORT + 1);

    // R2 / R8 vector walk in operation
    for (int i = 0; i < NV; i++) begin
      {mute_ni, mod_p_i, mod_m_i} = VEC[i][9:5];
      step();
      chk("R2 pass p", pwm_p_o, VEC[i][4:3]);
      chk("R2 pass m", pwm_m_o, VEC[i][2:1]);
      chk("R8 soft", soft_mute_o, VEC[i][0]);
      chk("R8 valid kept", valid_o, 2'b11);
    end
    mute_ni = 1;

    // R9: power-down in operation, then long re-init
    pdn_ni = 0;
    step();
    chk("R9 valid low", valid_o, 0);
    chk("R9 hard", hard_mute_o, 1);
    mute_ni = 0; mod_p_i = 2'b11; mod_m_i = 2'b00;
    step();
    chk("R8 no soft in hard mute", soft_mute_o, 0);
    chk("R2 force p", pwm_p_o, 0);
    chk("R2 force m", pwm_m_o, 2'b11);
    mute_ni = 1;
    pdn_ni = 1;
    edges_to_valid("R9 long after pdn", LONG + 1);

    // R6: lock loss, hold, short re-init
    lock_i = 0;
    step();
    chk("R6 valid low", valid_o, 0);
    repeat (LONG + 5) step();
    chk("R6 held", valid_o, 0);
    lock_i = 1;
    edges_to_valid("R6 short after lock", SHORT + 1);

    // R7: mode change in operation
    mode_i = 3'd5;
    step();
    chk("R7 valid low", valid_o, 0);
    chk("R7 hard", hard_mute_o, 1);
    edges_to_valid("R7 short after mode", SHORT + 1);

    // R3: pdn low across reset, released later
    rst_ni = 0; pdn_ni = 0;
    step();
    rst_ni = 1;
    repeat (30) step();
    chk("R3 waiting", valid_o, 0);
    pdn_ni = 1;
    edges_to_valid("R3 long after pdn release", LONG + 1);
    chk("R10 both valid", valid_o, 2'b11);

    finish_run();
  end
endmodule